// File: doc/BRIEF.md
# Page-Mode Read Access Controller

This block is the read path of a word-wide flash array with page mode. A host presents an address with chip enable and output enable held active. The block returns the addressed word after a latency counted in clock cycles. An access that lands in the page already held in an 8-word buffer is served at a short latency. Any other access, or the first access after chip enable returns, refills the buffer from a synchronous backing array and takes the full latency.

A data-valid strobe marks the cycle from which the output word belongs to the current address. When the address has not moved for the random-access time plus a margin, the block enters an automatic sleep state. In that state the word stays latched on the outputs until the next address change. The output drive is controlled through a separate enable, which models the pad tristate.

Top module: `pm_read_ctrl`

## Requirements
- R1: While `rst_ni` is low the block holds `dvalid_o`, `sleep_o` and `dq_oe_o` at 0 and `dq_o` at 0. In the first cycle after release, `dvalid_o` and `sleep_o` are still 0.
- R2: The backing array holds, at word address A, the value A[15:0] XOR 16'hC3A5 XOR A[21:16] (zero-extended). A completed read presents that value on `dq_o`.
- R3: Address bits [21:3] select a page and bits [2:0] select a word inside it. An access that keeps the bits of a completely loaded page and changes only bits [2:0] sets `dvalid_o` T_PAGE (default 5) edges after the edge that samples the new address.
- R4: An access to a page other than the loaded one sets `dvalid_o` T_RAND (default 13) edges after the edge that samples the new address.
- R5: While `ce_i` is low, `dvalid_o` and `sleep_o` are 0 and the page is discarded. The first access after `ce_i` returns takes the full T_RAND latency, even for the same address.
- R6: `dq_oe_o` is 1 only when `rst_ni`, `ce_i` and `oe_i` are all 1. While it is 0, `dq_o` is 0. Toggling `oe_i` does not disturb the latched word.
- R7: `dvalid_o` is 0 after the edge that samples a changed address.
- R8: `sleep_o` rises T_RAND + T_SLEEP (default 19) edges after the edge that samples the address, provided the address stays stable. While `sleep_o` is 1, `dvalid_o` stays 1 and `dq_o` stays unchanged.
- R9: An address change during sleep clears `sleep_o` at the sampling edge and starts a normal access. That access is a page hit if the page is kept.
- R10: Addresses presented while `rst_ni` is low are ignored. The first access after release takes the full T_RAND latency.
- R11: If only bits [2:0] change while the page is still being loaded, the page does not count as loaded. The new access takes the full T_RAND latency from its sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| ce_i | input | 1 | Chip enable, active high |
| oe_i | input | 1 | Output enable, active high |
| addr_i | input | ADDR_W | Word address |
| dq_o | output | DATA_W | Read data, 0 when not driven |
| dq_oe_o | output | 1 | Output drive enable (pad tristate control) |
| dvalid_o | output | 1 | Data for the current address is available |
| sleep_o | output | 1 | Automatic low-power hold is active |

## Verification
The properties assume that `rst_ni` is held low from time zero. They also assume that the inputs change only between clock edges, so each edge samples one settled address. The stimulus changes `addr_i`, `ce_i`, `oe_i` and `rst_ni` only on falling clock edges. It starts with reset asserted, which keeps every `$past` reference inside the cycles after reset. The default T_RAND is large enough to cover the eight-word page load, and the stimulus keeps that default.

// File: rtl/pm_pkg.sv
// Package: shared types and the backing-array content rule of the page-mode
// read controller. Assumes addresses fit in 64 bits.
package pm_pkg;

    // Access timer phases.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WAIT  = 2'd1,
        ACC_READY = 2'd2
    } acc_state_e;

    // Content of the backing array at word address a (caller truncates).
    function automatic logic [63:0] pm_cell_word(input logic [63:0] a);
        return a ^ 64'hC3A5 ^ (a >> 16);
    endfunction

endpackage

// File: rtl/pm_backing_rom.sv
// Module: synchronous backing array. Returns the word at rd_addr_i one cycle
// after the request. Content is computed, so any depth costs no storage.
module pm_backing_rom
    import pm_pkg::*;
#(
    parameter int AW = 22,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rd_en_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o
);

    // Registered read of the computed cell contents.
    always_ff @(posedge clk) begin
        if (rd_en_i) begin
            rd_data_o <= DW'(pm_cell_word(64'(rd_addr_i)));
        end
    end

endmodule

// File: rtl/pm_page_buf.sv
// Module: page buffer with its fill sequencer. On fill_i it loads all words
// of one page from the backing array, one request per cycle. valid_o rises
// only when the last word is written. Assumes a one-cycle backing latency.
module pm_page_buf #(
    parameter int AW = 22,
    parameter int DW = 16,
    parameter int PB = 3
) (
    input  logic             clk,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             fill_i,
    input  logic [AW-PB-1:0] fill_page_i,
    input  logic [PB-1:0]    rd_word_i,
    output logic [DW-1:0]    rd_data_o,
    output logic             valid_o,
    output logic [AW-PB-1:0] tag_o,
    output logic             rom_en_o,
    output logic [AW-1:0]    rom_addr_o,
    input  logic [DW-1:0]    rom_data_i
);

    localparam int PW = 1 << PB;
    localparam logic [PB-1:0] LAST_IDX = '1;

    logic          active_q;
    logic [PB-1:0] issue_q;
    logic          wr_en_q;
    logic [PB-1:0] wr_idx_q;
    logic [DW-1:0] mem [PW];

    assign rom_en_o   = active_q;
    assign rom_addr_o = {tag_o, issue_q};
    assign rd_data_o  = mem[rd_word_i];

    // Fill sequencing: issue requests, track the write slot, mark completion.
    always_ff @(posedge clk) begin
        if (!rst_ni || clear_i) begin
            active_q <= 1'b0;
            issue_q  <= '0;
            wr_en_q  <= 1'b0;
            wr_idx_q <= '0;
            valid_o  <= 1'b0;
            tag_o    <= '0;
        end else if (fill_i) begin
            active_q <= 1'b1;
            issue_q  <= '0;
            wr_en_q  <= 1'b0;
            valid_o  <= 1'b0;
            tag_o    <= fill_page_i;
        end else begin
            wr_en_q  <= active_q;
            wr_idx_q <= issue_q;
            if (active_q) begin
                issue_q <= issue_q + 1'b1;
                if (issue_q == LAST_IDX) active_q <= 1'b0;
            end
            if (wr_en_q && wr_idx_q == LAST_IDX) valid_o <= 1'b1;
        end
    end

    // One storage word per page slot, written when its response returns.
    for (genvar g = 0; g < PW; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en_q && wr_idx_q == PB'(g)) mem[g] <= rom_data_i;
        end
    end

endmodule

// File: rtl/pm_access_timer.sv
// Module: access latency and stability timer. start_i begins an access of
// T_PAGE (hit_i) or T_RAND cycles. The sleep flag rises once the address has
// been stable for T_RAND + T_SLEEP cycles. Assumes T_SLEEP >= 1.
module pm_access_timer
    import pm_pkg::*;
#(
    parameter int T_RAND  = 13,
    parameter int T_PAGE  = 5,
    parameter int T_SLEEP = 6
) (
    input  logic clk,
    input  logic rst_ni,
    input  logic ce_i,
    input  logic start_i,
    input  logic hit_i,
    output logic load_o,
    output logic dvalid_o,
    output logic sleep_o
);

    localparam int SLP_LIM = T_RAND + T_SLEEP;
    localparam int CNT_W   = $clog2(T_RAND + 1);
    localparam int STB_W   = $clog2(SLP_LIM + 1);

    acc_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [STB_W-1:0] stab_q;

    assign load_o   = ce_i && !start_i && state_q == ACC_WAIT && cnt_q == '0;
    assign dvalid_o = state_q == ACC_READY;

    // Latency countdown, stability count and sleep entry.
    always_ff @(posedge clk) begin
        if (!rst_ni || !ce_i) begin
            state_q <= ACC_IDLE;
            cnt_q   <= '0;
            stab_q  <= '0;
            sleep_o <= 1'b0;
        end else if (start_i) begin
            state_q <= ACC_WAIT;
            cnt_q   <= hit_i ? CNT_W'(T_PAGE - 1) : CNT_W'(T_RAND - 1);
            stab_q  <= '0;
            sleep_o <= 1'b0;
        end else begin
            if (state_q == ACC_WAIT) begin
                if (cnt_q == '0) state_q <= ACC_READY;
                else             cnt_q   <= cnt_q - 1'b1;
            end
            if (state_q != ACC_IDLE && stab_q != STB_W'(SLP_LIM - 1)) begin
                stab_q <= stab_q + 1'b1;
            end
            if (stab_q == STB_W'(SLP_LIM - 1)) sleep_o <= 1'b1;
        end
    end

endmodule

// File: rtl/pm_read_ctrl.sv
// Module: page-mode read access controller (top). Detects new accesses,
// decides page hit or miss, drives the page buffer and the timer, and
// latches and gates the output word. Assumes inputs settle between edges.
module pm_read_ctrl
    import pm_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int DATA_W    = 16,
    parameter int PAGE_BITS = 3,
    parameter int T_RAND    = 13,
    parameter int T_PAGE    = 5,
    parameter int T_SLEEP   = 6
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              ce_i,
    input  logic              oe_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    output logic              dvalid_o,
    output logic              sleep_o
);

    localparam int PG_W = ADDR_W - PAGE_BITS;

    logic              ce_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              start, hit, load;
    logic              pg_valid;
    logic [PG_W-1:0]   pg_tag;
    logic [DATA_W-1:0] buf_word;
    logic              rom_en;
    logic [ADDR_W-1:0] rom_addr;
    logic [DATA_W-1:0] rom_data;

    assign start   = ce_i && (!ce_q || addr_i != addr_q);
    assign hit     = pg_valid && addr_i[ADDR_W-1:PAGE_BITS] == pg_tag;
    assign dq_oe_o = rst_ni && ce_i && oe_i;
    assign dq_o    = dq_oe_o ? data_q : '0;

    // Address and enable history for access detection.
    always_ff @(posedge clk) begin
        if (!rst_ni) begin
            ce_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            ce_q   <= ce_i;
            addr_q <= addr_i;
        end
    end

    // Output latch: captured at access completion, held through sleep.
    always_ff @(posedge clk) begin
        if (!rst_ni)   data_q <= '0;
        else if (load) data_q <= buf_word;
    end

    pm_backing_rom #(.AW(ADDR_W), .DW(DATA_W)) rom_i (
        .clk       (clk),
        .rd_en_i   (rom_en),
        .rd_addr_i (rom_addr),
        .rd_data_o (rom_data)
    );

    pm_page_buf #(.AW(ADDR_W), .DW(DATA_W), .PB(PAGE_BITS)) page_i (
        .clk         (clk),
        .rst_ni      (rst_ni),
        .clear_i     (!ce_i),
        .fill_i      (start && !hit),
        .fill_page_i (addr_i[ADDR_W-1:PAGE_BITS]),
        .rd_word_i   (addr_q[PAGE_BITS-1:0]),
        .rd_data_o   (buf_word),
        .valid_o     (pg_valid),
        .tag_o       (pg_tag),
        .rom_en_o    (rom_en),
        .rom_addr_o  (rom_addr),
        .rom_data_i  (rom_data)
    );

    pm_access_timer #(.T_RAND(T_RAND), .T_PAGE(T_PAGE), .T_SLEEP(T_SLEEP)) tmr_i (
        .clk      (clk),
        .rst_ni   (rst_ni),
        .ce_i     (ce_i),
        .start_i  (start),
        .hit_i    (hit),
        .load_o   (load),
        .dvalid_o (dvalid_o),
        .sleep_o  (sleep_o)
    );

endmodule

// File: rtl/pm_read_ctrl_chk.sv
// Module: property checker for the page-mode read controller, bound to the
// top. Observes ports only. Assumes reset is low from time zero.
module pm_read_ctrl_chk #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_ni,
    input logic              ce_i,
    input logic              oe_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe_o,
    input logic              dvalid_o,
    input logic              sleep_o
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(rst_ni) |-> !dvalid_o && !sleep_o); // R1

    AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
        !oe_i |-> !dq_oe_o && dq_o == '0); // R6

    AST_CE_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
        !ce_i |=> !dvalid_o && !sleep_o); // R5

    AST_CE_RETURN_WAIT: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(ce_i) |=> !dvalid_o); // R5

    AST_ADDR_DROP: assert property (@(posedge clk) disable iff (!rst_ni)
        ce_i && $past(ce_i) && addr_i != $past(addr_i) |=> !dvalid_o); // R7

    AST_SLEEP_VALID: assert property (@(posedge clk) disable iff (!rst_ni)
        sleep_o |-> dvalid_o); // R8

    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
        sleep_o && $past(sleep_o) && dq_oe_o && $past(dq_oe_o) |-> $stable(dq_o)); // R8

    AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_ni)
        ce_i && $past(ce_i) && addr_i != $past(addr_i) |=> !sleep_o); // R9

endmodule

bind pm_read_ctrl pm_read_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/pm_read_ctrl_tb_top.sv
// Bench: table-driven access sequence, then directed tests for reset,
// enables, sleep and fill corner cases. Reports through its own counters.
module pm_read_ctrl_tb_top;

    localparam int AW = 22;
    localparam int DW = 16;
    localparam int LAT_R = 13;
    localparam int LAT_P = 5;
    localparam int SLP = LAT_R + 6;

    // {expect_hit, address}
    localparam logic [AW:0] VEC [9] = '{
        {1'b0, 22'h000010}, {1'b1, 22'h000013}, {1'b1, 22'h000017},
        {1'b1, 22'h000010}, {1'b0, 22'h123458}, {1'b1, 22'h12345F},
        {1'b0, 22'h3FFFF8}, {1'b1, 22'h3FFFFF}, {1'b0, 22'h000012}
    };

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          ce_i = 1'b1;
    logic          oe_i = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe_o, dvalid_o, sleep_o;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    pm_read_ctrl dut_i (
        .clk(clk), .rst_ni(rst_ni), .ce_i(ce_i), .oe_i(oe_i), .addr_i(addr_i),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dvalid_o(dvalid_o), .sleep_o(sleep_o)
    );

    function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a);
        return a[15:0] ^ 16'hC3A5 ^ {10'd0, a[21:16]};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Count falling-edge samples until dvalid_o, starting after an input change.
    task automatic wait_ready(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) chk(dvalid_o == 1'b0, "R7", 32'(dvalid_o), 0);
        end while (!dvalid_o && n < 60);
    endtask

    task automatic access(input logic [AW-1:0] a, input int lat, input string rq);
        int n;
        @(negedge clk);
        addr_i = a;
        wait_ready(n);
        chk(n == lat + 1, rq, 32'(n), 32'(lat + 1));
        chk(dq_o == exp_word(a), "R2", 32'(dq_o), 32'(exp_word(a)));
    endtask

    initial begin
        int n;
        logic [DW-1:0] held;
        // R1 / R10: reset held with requests presented
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            addr_i = 22'(i * 8 + 3);
            #1;
            chk(!dvalid_o && !sleep_o && !dq_oe_o && dq_o == '0, "R1",
                {dvalid_o, sleep_o, dq_oe_o, 13'd0, dq_o}, 0);
        end
        // R10: first access after release takes full latency
        @(negedge clk);
        addr_i = 22'h000020;
        rst_ni = 1'b1;
        wait_ready(n);
        chk(n == LAT_R + 1, "R10", 32'(n), 32'(LAT_R + 1));
        chk(dq_o == exp_word(22'h000020), "R2", 32'(dq_o), 32'(exp_word(22'h000020)));

        // R2/R3/R4/R7: table walk
        for (int v = 0; v < 9; v++) begin
            access(VEC[v][AW-1:0], VEC[v][AW] ? LAT_P : LAT_R, VEC[v][AW] ? "R3" : "R4");
        end

        // R8: sleep entry after a stable address
        @(negedge clk);
        addr_i = 22'h0ABCD0;
        for (int c = 1; c <= 25; c++) begin
            @(negedge clk);
            if (c == SLP) chk(sleep_o == 1'b0, "R8", 32'(sleep_o), 0);
            if (c == SLP + 1) begin
                chk(sleep_o == 1'b1, "R8", 32'(sleep_o), 1);
                held = dq_o;
            end
        end
        chk(sleep_o && dvalid_o && dq_o == held && held == exp_word(22'h0ABCD0), "R8",
            32'(dq_o), 32'(exp_word(22'h0ABCD0)));

        // R9: wake on address change within the page, hit latency
        @(negedge clk);
        addr_i = 22'h0ABCD5;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) chk(sleep_o == 1'b0 && dvalid_o == 1'b0, "R9",
                            {sleep_o, dvalid_o}, 0);
        end while (!dvalid_o && n < 60);
        chk(n == LAT_P + 1, "R9", 32'(n), 32'(LAT_P + 1));
        chk(dq_o == exp_word(22'h0ABCD5), "R9", 32'(dq_o), 32'(exp_word(22'h0ABCD5)));

        // R5: chip enable cycle discards the page
        @(negedge clk);
        ce_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!dvalid_o && !sleep_o && !dq_oe_o, "R5", {dvalid_o, sleep_o, dq_oe_o}, 0);
        ce_i = 1'b1;
        wait_ready(n);
        chk(n == LAT_R + 1, "R5", 32'(n), 32'(LAT_R + 1));

        // R6: output enable gating leaves the word intact
        @(negedge clk);
        oe_i = 1'b0;
        #1;
        chk(!dq_oe_o && dq_o == '0, "R6", {dq_oe_o, dq_o}, 0);
        @(negedge clk);
        oe_i = 1'b1;
        #1;
        chk(dq_oe_o && dq_o == exp_word(22'h0ABCD5), "R6", 32'(dq_o),
            32'(exp_word(22'h0ABCD5)));

        // R11: word change while the page is still loading
        @(negedge clk);
        addr_i = 22'h155550;
        repeat (3) @(negedge clk);
        addr_i = 22'h155553;
        wait_ready(n);
        chk(n == LAT_R + 1, "R11", 32'(n), 32'(LAT_R + 1));
        chk(dq_o == exp_word(22'h155553), "R11", 32'(dq_o), 32'(exp_word(22'h155553)));
        access(22'h155556, LAT_P, "R3");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule